// File: doc/BRIEF.md
# CPU Address Space Decoder

This block sits between a CPU's 16-bit address bus and the memories and register files around it. It looks at the address and the current bank settings, raises one region select while a read or write strobe is active, and produces a physical address for that region. The physical address is built by joining the active bank number above the offset inside the region. Read data from every target comes in on one packed bus. The decoder passes back the byte from the region the address falls in.

All logic in the block is combinational. The bank registers are held outside the block and reach it as plain inputs. A write into the ROM window only raises the ROM select. What that write means is decided elsewhere. Several decode rules go beyond plain ranges:
- The work RAM appears a second time higher in the map.
- The upper work-RAM window maps a bank number of zero to bank one.
- Some addresses are holes that read back 0xFF.
- The very last address belongs to the I/O register file and not to high RAM.

Top module: `amd_cpu_addr_decode`

## Requirements
- R1: Addresses 0x0000–0x3FFF raise select bit 0 (ROM). The physical address is addr[13:0] with a bank field of zero, whatever the value of rom_bank.
- R2: Addresses 0x4000–0x7FFF raise select bit 0 (ROM). The physical address is {rom_bank, addr[13:0]}.
- R3: Addresses 0x8000–0x9FFF raise select bit 1 (VRAM). The physical address is {vram_bank, addr[12:0]}.
- R4: Addresses 0xA000–0xBFFF raise select bit 2 (external RAM) only while xram_en is 1. The physical address is then {xram_bank, addr[12:0]}. While xram_en is 0, no select is raised for reads or writes, and a read returns 0xFF.
- R5: Addresses 0xC000–0xCFFF raise select bit 3 (work RAM) with physical address {0, addr[11:0]}. Addresses 0xD000–0xDFFF raise select bit 3 with physical address {b, addr[11:0]}, where b is wram_bank, or 1 when wram_bank is 0.
- R6: Addresses 0xE000–0xFDFF decode exactly like the same address with bit 13 cleared. They raise select bit 3 and follow the bank rule of R5.
- R7: Addresses 0xFE00–0xFE9F raise select bit 4 (sprite attributes) with physical address addr[7:0]. Addresses 0xFEA0–0xFEFF raise no select and read 0xFF.
- R8: In the 0xFFxx page the selects are as follows:
  - 0xFF10–0xFF3F raise bit 5 (sound).
  - 0xFF80–0xFFFE raise bit 6 (high RAM).
  - 0xFFFF and every other 0xFFxx address raise bit 7 (I/O registers).
  - For all of these, the physical address is addr[7:0].
- R9: cpu_rdata equals tgt_rdata[8*k+7:8*k] for the region k that the address decodes to. It does so whether or not a strobe is active.
- R10: At most one select bit is ever high. No select is high while cpu_rd and cpu_wr are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| rom_bank | input | ROM_BANK_W (9) | ROM bank for the upper ROM window |
| vram_bank | input | 1 | Video RAM bank (bit 0 of the bank register) |
| wram_bank | input | WRAM_BANK_W (3) | Work-RAM bank for the upper work-RAM window |
| xram_bank | input | XRAM_BANK_W (4) | External RAM bank |
| xram_en | input | 1 | External RAM enable |
| tgt_rdata | input | 64 | Read data of region k on bits 8k+7:8k |
| rgn_sel | output | 8 | One-hot region select, bit positions as in R1–R8 |
| phys_addr | output | PHYS_W (23) | Physical address, zero-extended |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The hardest points to reach are the edges where two rules meet:
- the bank-zero substitution at work-RAM addresses reached through the echo window;
- the last echo address just below the sprite area;
- the boundaries of the 0xFFxx page, where sound, I/O and high RAM meet at 0xFF0F/0xFF10, 0xFF3F/0xFF40, 0xFF7F/0xFF80 and 0xFFFE/0xFFFF.

The stimulus places the address exactly on each side of each boundary. Before each probe it programs the bank inputs so that a zero or non-zero bank value changes the expected physical address. Each region's read byte is distinct, so any wrong steering shows up in cpu_rdata.

// File: rtl/amd_pkg.sv
package amd_pkg;

    localparam int NUM_RGN = 8;

    typedef enum logic [3:0] {
        RGN_ROM  = 4'd0,
        RGN_VRAM = 4'd1,
        RGN_XRAM = 4'd2,
        RGN_WRAM = 4'd3,
        RGN_OAM  = 4'd4,
        RGN_SND  = 4'd5,
        RGN_HRAM = 4'd6,
        RGN_IO   = 4'd7,
        RGN_NONE = 4'd8
    } rgn_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/amd_region_decode.sv
module amd_region_decode
    import amd_pkg::*;
(
    input  logic [15:0]        addr,
    input  logic               strobe,
    input  logic               xram_en,
    output rgn_t               region,
    output logic [NUM_RGN-1:0] sel
);

    typedef struct packed {
        rgn_t region;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d.region = RGN_NONE;
        case (addr[15:12])
            4'h0, 4'h1, 4'h2, 4'h3,
            4'h4, 4'h5, 4'h6, 4'h7: dec_d.region = RGN_ROM;
            4'h8, 4'h9:             dec_d.region = RGN_VRAM;
            4'hA, 4'hB:             dec_d.region = xram_en ? RGN_XRAM : RGN_NONE;
            4'hC, 4'hD, 4'hE:       dec_d.region = RGN_WRAM;
            default: begin
                if (addr[11:8] != 4'hE && addr[11:8] != 4'hF) begin
                    dec_d.region = RGN_WRAM;
                end else if (addr[11:8] == 4'hE) begin
                    dec_d.region = (addr[7:0] < 8'hA0) ? RGN_OAM : RGN_NONE;
                end else if (addr[7:0] >= 8'h10 && addr[7:0] <= 8'h3F) begin
                    dec_d.region = RGN_SND;
                end else if (addr[7] && addr[7:0] != 8'hFF) begin
                    dec_d.region = RGN_HRAM;
                end else begin
                    dec_d.region = RGN_IO;
                end
            end
        endcase
    end

    assign region = dec_d.region;

    for (genvar i = 0; i < NUM_RGN; i++) begin : g_sel
        assign sel[i] = strobe && (dec_d.region == rgn_t'(i));
    end

endmodule

// File: rtl/amd_offset_xlate.sv
module amd_offset_xlate
    import amd_pkg::*;
#(
    parameter int ROM_BANK_W  = 9,
    parameter int WRAM_BANK_W = 3,
    parameter int XRAM_BANK_W = 4,
    parameter int PHYS_W      = 23
) (
    input  rgn_t                   region,
    input  logic [14:0]            addr,
    input  logic [ROM_BANK_W-1:0]  rom_bank,
    input  logic                   vram_bank,
    input  logic [WRAM_BANK_W-1:0] wram_bank,
    input  logic [XRAM_BANK_W-1:0] xram_bank,
    output logic [PHYS_W-1:0]      phys
);

    typedef struct packed {
        logic [ROM_BANK_W-1:0]  rom_bank;
        logic [WRAM_BANK_W-1:0] wram_bank;
        logic [PHYS_W-1:0]      phys;
    } xl_t;

    xl_t xl_d;

    always_comb begin
        xl_d.rom_bank  = addr[14] ? rom_bank : '0;
        xl_d.wram_bank = '0;
        if (addr[12]) begin
            xl_d.wram_bank = (wram_bank == '0) ? WRAM_BANK_W'(1) : wram_bank;
        end
        case (region)
            RGN_ROM:  xl_d.phys = PHYS_W'({xl_d.rom_bank, addr[13:0]});
            RGN_VRAM: xl_d.phys = PHYS_W'({vram_bank, addr[12:0]});
            RGN_XRAM: xl_d.phys = PHYS_W'({xram_bank, addr[12:0]});
            RGN_WRAM: xl_d.phys = PHYS_W'({xl_d.wram_bank, addr[11:0]});
            RGN_OAM, RGN_SND, RGN_HRAM, RGN_IO:
                      xl_d.phys = PHYS_W'(addr[7:0]);
            default:  xl_d.phys = '0;
        endcase
    end

    assign phys = xl_d.phys;

endmodule

// File: rtl/amd_read_steer.sv
module amd_read_steer
    import amd_pkg::*;
(
    input  rgn_t                 region,
    input  logic [NUM_RGN*8-1:0] tgt_rdata,
    output logic [7:0]           rdata
);

    logic [7:0] lane [NUM_RGN];

    for (genvar i = 0; i < NUM_RGN; i++) begin : g_lane
        assign lane[i] = tgt_rdata[i*8 +: 8];
    end

    always_comb begin
        rdata = 8'hFF;
        for (int k = 0; k < NUM_RGN; k++) begin
            if (region == rgn_t'(k)) rdata = lane[k];
        end
    end

endmodule

// File: rtl/amd_cpu_addr_decode.sv
module amd_cpu_addr_decode
    import amd_pkg::*;
#(
    parameter int ROM_BANK_W  = 9,
    parameter int WRAM_BANK_W = 3,
    parameter int XRAM_BANK_W = 4,
    localparam int PHYS_W = imax(imax(ROM_BANK_W + 14, XRAM_BANK_W + 13),
                                 imax(WRAM_BANK_W + 12, 14))
) (
    input  logic [15:0]            cpu_addr,
    input  logic                   cpu_rd,
    input  logic                   cpu_wr,
    input  logic [ROM_BANK_W-1:0]  rom_bank,
    input  logic                   vram_bank,
    input  logic [WRAM_BANK_W-1:0] wram_bank,
    input  logic [XRAM_BANK_W-1:0] xram_bank,
    input  logic                   xram_en,
    input  logic [NUM_RGN*8-1:0]   tgt_rdata,
    output logic [NUM_RGN-1:0]     rgn_sel,
    output logic [PHYS_W-1:0]      phys_addr,
    output logic [7:0]             cpu_rdata
);

    rgn_t region;

    amd_region_decode u_dec (
        .addr    (cpu_addr),
        .strobe  (cpu_rd | cpu_wr),
        .xram_en (xram_en),
        .region  (region),
        .sel     (rgn_sel)
    );

    amd_offset_xlate #(
        .ROM_BANK_W  (ROM_BANK_W),
        .WRAM_BANK_W (WRAM_BANK_W),
        .XRAM_BANK_W (XRAM_BANK_W),
        .PHYS_W      (PHYS_W)
    ) u_xl (
        .region    (region),
        .addr      (cpu_addr[14:0]),
        .rom_bank  (rom_bank),
        .vram_bank (vram_bank),
        .wram_bank (wram_bank),
        .xram_bank (xram_bank),
        .phys      (phys_addr)
    );

    amd_read_steer u_rs (
        .region    (region),
        .tgt_rdata (tgt_rdata),
        .rdata     (cpu_rdata)
    );

    always_comb begin
        // R10
        sel_onehot_chk: assert ($onehot0(rgn_sel));
        // R4
        xram_gate_chk: assert (xram_en || !rgn_sel[RGN_XRAM]);
        // R5
        wram_bank_nz_chk: assert (!(rgn_sel[RGN_WRAM] && cpu_addr[12])
                                  || phys_addr[12 +: WRAM_BANK_W] != '0);
        // R3
        vram_range_chk: assert (!rgn_sel[RGN_VRAM] || phys_addr[PHYS_W-1:14] == '0);
        // R9
        hole_ff_chk: assert (!(cpu_rd && rgn_sel == '0) || cpu_rdata == 8'hFF);
    end

endmodule

// File: tb/sim_amd_cpu_addr_decode.sv
module sim_amd_cpu_addr_decode;

    logic        clk = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [8:0]  rom_bank = '0;
    logic        vram_bank = 1'b0;
    logic [2:0]  wram_bank = '0;
    logic [3:0]  xram_bank = '0;
    logic        xram_en = 1'b0;
    logic [63:0] tgt_rdata;
    logic [7:0]  rgn_sel;
    logic [22:0] phys_addr;
    logic [7:0]  cpu_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    amd_cpu_addr_decode u0 (
        .cpu_addr  (addr),
        .cpu_rd    (rd),
        .cpu_wr    (wr),
        .rom_bank  (rom_bank),
        .vram_bank (vram_bank),
        .wram_bank (wram_bank),
        .xram_bank (xram_bank),
        .xram_en   (xram_en),
        .tgt_rdata (tgt_rdata),
        .rgn_sel   (rgn_sel),
        .phys_addr (phys_addr),
        .cpu_rdata (cpu_rdata)
    );

    function automatic logic [7:0] dat(input int k);
        return (k < 0) ? 8'hFF : 8'(8'hA0 + k);
    endfunction

    task automatic probe(input logic [15:0] a, input logic r, input logic w,
                         input int k, input logic cp, input logic [22:0] ep,
                         input string tag);
        logic [7:0] es;
        es = (k < 0 || !(r || w)) ? 8'h00 : 8'(1 << k);
        @(negedge clk);
        addr = a; rd = r; wr = w;
        #1;
        checks++;
        if (rgn_sel !== es) begin
            errors++;
            $display("FAIL %s addr=%h sel actual=%h expected=%h", tag, a, rgn_sel, es);
        end
        if (cp) begin
            checks++;
            if (phys_addr !== ep) begin
                errors++;
                $display("FAIL %s addr=%h phys actual=%h expected=%h", tag, a, phys_addr, ep);
            end
        end
        checks++;
        if (cpu_rdata !== dat(k)) begin
            errors++;
            $display("FAIL %s addr=%h rdata actual=%h expected=%h", tag, a, cpu_rdata, dat(k));
        end
    endtask

    task automatic t_idle();
        probe(16'h1234, 0, 0, 0, 1, 23'h1234, "R10 idle no strobe");
        probe(16'hFF80, 0, 0, 6, 0, '0, "R10 idle hram");
    endtask

    task automatic t_rom();
        rom_bank = 9'h1A5;
        probe(16'h2ABC, 1, 0, 0, 1, 23'h2ABC, "R1 fixed rom");
        probe(16'h3FFF, 0, 1, 0, 1, 23'h3FFF, "R1 fixed rom top");
        probe(16'h5123, 1, 0, 0, 1, {9'h1A5, 14'h1123}, "R2 banked rom");
        rom_bank = 9'h000;
        probe(16'h4000, 1, 0, 0, 1, 23'h0000, "R2 banked rom bank0");
    endtask

    task automatic t_vram();
        vram_bank = 1'b0;
        probe(16'h9F00, 1, 0, 1, 1, 23'h1F00, "R3 vram bank0");
        vram_bank = 1'b1;
        probe(16'h8001, 0, 1, 1, 1, 23'h2001, "R3 vram bank1");
    endtask

    task automatic t_xram();
        xram_en = 1'b1; xram_bank = 4'hB;
        probe(16'hB123, 1, 0, 2, 1, {6'h0, 4'hB, 13'h1123}, "R4 xram enabled");
        xram_en = 1'b0;
        probe(16'hA010, 1, 0, -1, 0, '0, "R4 xram disabled read");
        probe(16'hA010, 0, 1, -1, 0, '0, "R4 xram disabled write");
    endtask

    task automatic t_wram();
        wram_bank = 3'd5;
        probe(16'hC456, 1, 0, 3, 1, 23'h0456, "R5 wram bank0");
        probe(16'hD456, 1, 0, 3, 1, 23'h5456, "R5 wram bank n");
        wram_bank = 3'd0;
        probe(16'hD456, 0, 1, 3, 1, 23'h1456, "R5 wram zero means one");
    endtask

    task automatic t_echo();
        wram_bank = 3'd3;
        probe(16'hE456, 1, 0, 3, 1, 23'h0456, "R6 echo low");
        probe(16'hF456, 1, 0, 3, 1, 23'h3456, "R6 echo banked");
        wram_bank = 3'd0;
        probe(16'hFDFF, 1, 0, 3, 1, 23'h1DFF, "R6 echo top zero bank");
    endtask

    task automatic t_oam();
        probe(16'hFE00, 1, 0, 4, 1, 23'h0000, "R7 oam first");
        probe(16'hFE9F, 1, 0, 4, 1, 23'h009F, "R7 oam last");
        probe(16'hFEA0, 1, 0, -1, 0, '0, "R7 hole first");
        probe(16'hFEFF, 0, 1, -1, 0, '0, "R7 hole last");
    endtask

    task automatic t_high();
        probe(16'hFF0F, 1, 0, 7, 1, 23'h0F, "R8 io below sound");
        probe(16'hFF10, 1, 0, 5, 1, 23'h10, "R8 sound first");
        probe(16'hFF3F, 0, 1, 5, 1, 23'h3F, "R8 sound last");
        probe(16'hFF40, 1, 0, 7, 1, 23'h40, "R8 io above sound");
        probe(16'hFF7F, 1, 0, 7, 1, 23'h7F, "R8 io last");
        probe(16'hFF80, 1, 0, 6, 1, 23'h80, "R8 hram first");
        probe(16'hFFFE, 1, 0, 6, 1, 23'hFE, "R8 hram last");
        probe(16'hFFFF, 1, 0, 7, 1, 23'hFF, "R8 R9 top io");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) tgt_rdata[i*8 +: 8] = dat(i);
        repeat (2) @(posedge clk);
        t_idle();
        t_rom();
        t_vram();
        t_xram();
        t_wram();
        t_echo();
        t_oam();
        t_high();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule